// File: doc/BRIEF.md
# Soft Interrupt Pending Controller

This block keeps the software-visible record of pending soft interrupts for one processor thread, together with the current processor interrupt level (PIL). It combines the two into a vector of interrupt requests with one bit per source. Downstream trap logic takes this vector and decides what to deliver.

Software writes through a small register bus with four write targets, chosen by `wr_sel`. Three of them act on the pending word: a direct load, an OR-in, and a bit clear. The fourth loads the interrupt level. A single-cycle pulse from a timer comparator marks the timer source pending without software involvement.

The request vector uses two masking rules. The two timer-type sources, bit 0 and bit 16, are gated by a fixed threshold: they request only while the level is below 14. Every other source n requests only when n is strictly greater than the level. The request vector is registered and changes at the same clock edge as the state that produces it.

Top module: `sip_ctrl`

## Requirements
- R1: When `rst_n` is low, the pending word, the interrupt level and `irq_req` all clear to zero.
- R2: A write with `wr_sel` = 0 replaces the pending word with `wr_data[16:0]`.
- R3: A write with `wr_sel` = 1 ORs `wr_data[16:0]` into the pending word.
- R4: A write with `wr_sel` = 2 clears every pending bit whose `wr_data` bit is one and leaves the other bits as they were.
- R5: A write with `wr_sel` = 3 loads the interrupt level from `wr_data[3:0]` and leaves the pending word unchanged.
- R6: For source n from 1 to 15, `irq_req[n]` is one only when pending bit n is set and n is greater than the level.
- R7: `irq_req[0]` and `irq_req[16]` each follow their pending bit only while the level is below 14. At a level of 14 or 15 they are zero.
- R8: A one on `tmr_hit` sets pending bit 16.
- R9: When `tmr_hit` and a bus write arrive in the same cycle, the write takes effect first and bit 16 is then set, so a clear or direct load cannot drop the timer event.
- R10: `rd_data` and `irq_req` reflect a write or timer pulse from the clock edge that accepts it. With no write and no pulse, both hold their values.
- R11: `rd_data` returns the pending word whatever the value of `wr_sel`. Bits 31 to 17 of `rd_data` read as zero, and `wr_data` bits above 16 have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Write target: 0 load, 1 set bits, 2 clear bits, 3 level |
| wr_data | input | 32 | Write data |
| tmr_hit | input | 1 | Timer comparator match pulse |
| rd_data | output | 32 | Pending word, zero-extended |
| irq_req | output | 17 | Masked per-source interrupt requests |

## Verification
Some properties are checked on every cycle. These are the next-state effect of each write target and of the timer pulse on the read value, the hold of state when nothing is written, the zero upper read bits, and both masking rules between the level and each request bit. Other behaviour needs the bench's scenarios to show it. That covers the reset values and the PIL 13/14 boundary for the timer-type bits. It also covers the case where a clear or load of bit 16 coincides with a timer pulse and bit 16 must still read as one. Finally, it covers level sweeps that move the cutoff across the middle sources.

// File: rtl/sip_pkg.sv
package sip_pkg;

   typedef enum logic [1:0] {
      SEL_LOAD  = 2'd0,
      SEL_SET   = 2'd1,
      SEL_CLEAR = 2'd2,
      SEL_LEVEL = 2'd3
   } sip_sel_e;

   // Applies one bus write to a pending word of up to 64 bits.
   function automatic logic [63:0] sip_apply(input logic [63:0] cur,
                                             input logic [63:0] val,
                                             input sip_sel_e    sel);
      logic [63:0] res;
      case (sel)
         SEL_LOAD:  res = val;
         SEL_SET:   res = cur | val;
         SEL_CLEAR: res = cur & ~val;
         default:   res = cur;
      endcase
      return res;
   endfunction

endpackage

// File: rtl/sip_pend_reg.sv
module sip_pend_reg
   import sip_pkg::*;
#(
   parameter int SRC_N     = 17,
   parameter int TIMER_BIT = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  sip_sel_e         sel,
   input  logic [SRC_N-1:0] data,
   input  logic             hit,
   output logic [SRC_N-1:0] pend_d,
   output logic [SRC_N-1:0] pend_q
);
   logic [63:0] applied;

   always_comb begin
      applied = sip_apply(64'(pend_q), 64'(data), sel);
      pend_d  = pend_q;
      if (wr_en) begin
         pend_d = applied[SRC_N-1:0];
      end
      // timer event lands after the bus write so it is never lost
      if (hit) begin
         pend_d[TIMER_BIT] = 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pend_q <= '0;
      end else begin
         pend_q <= pend_d;
      end
   end
endmodule

// File: rtl/sip_level_reg.sv
module sip_level_reg
   import sip_pkg::*;
#(
   parameter int LVL_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  sip_sel_e         sel,
   input  logic [LVL_W-1:0] data,
   output logic [LVL_W-1:0] lvl_d,
   output logic [LVL_W-1:0] lvl_q
);
   always_comb begin
      lvl_d = lvl_q;
      if (wr_en && sel == SEL_LEVEL) begin
         lvl_d = data;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         lvl_q <= '0;
      end else begin
         lvl_q <= lvl_d;
      end
   end
endmodule

// File: rtl/sip_req_mask.sv
module sip_req_mask #(
   parameter int               SRC_N     = 17,
   parameter int               LVL_W     = 4,
   parameter logic [SRC_N-1:0] FIXED_MSK = 17'h10001,
   parameter int               FIXED_THR = 14
) (
   input  logic [SRC_N-1:0] pend,
   input  logic [LVL_W-1:0] lvl,
   output logic [SRC_N-1:0] req
);
   logic below_thr;
   assign below_thr = (int'(lvl) < FIXED_THR);

   for (genvar g = 0; g < SRC_N; g++) begin : g_src
      if (FIXED_MSK[g]) begin : g_fixed
         assign req[g] = pend[g] & below_thr;
      end else begin : g_ranked
         assign req[g] = pend[g] & (int'(lvl) < g);
      end
   end
endmodule

// File: rtl/sip_ctrl.sv
module sip_ctrl
   import sip_pkg::*;
#(
   parameter int               SRC_N     = 17,
   parameter int               LVL_W     = 4,
   parameter int               BUS_W     = 32,
   parameter int               TIMER_BIT = 16,
   parameter logic [SRC_N-1:0] FIXED_MSK = 17'h10001,
   parameter int               FIXED_THR = 14
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [1:0]       wr_sel,
   input  logic [BUS_W-1:0] wr_data,
   input  logic             tmr_hit,
   output logic [BUS_W-1:0] rd_data,
   output logic [SRC_N-1:0] irq_req
);
   localparam int PAD_W = BUS_W - SRC_N;

   initial begin
      assert (SRC_N <= 64) else $error("SRC_N above 64");
      assert (BUS_W > SRC_N) else $error("BUS_W must exceed SRC_N");
      assert (BUS_W >= LVL_W) else $error("BUS_W narrower than LVL_W");
      assert (TIMER_BIT < SRC_N) else $error("TIMER_BIT out of range");
      assert (FIXED_THR <= (1 << LVL_W)) else $error("FIXED_THR out of range");
   end

   sip_sel_e         sel;
   logic [SRC_N-1:0] pend_d, pend_q;
   logic [LVL_W-1:0] lvl_d, lvl_q;
   logic [SRC_N-1:0] req_d;
   logic [SRC_N-1:0] req_q;

   assign sel = sip_sel_e'(wr_sel);

   sip_pend_reg #(.SRC_N(SRC_N), .TIMER_BIT(TIMER_BIT)) u_pend (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .sel(sel),
      .data(wr_data[SRC_N-1:0]), .hit(tmr_hit),
      .pend_d(pend_d), .pend_q(pend_q)
   );

   sip_level_reg #(.LVL_W(LVL_W)) u_lvl (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .sel(sel),
      .data(wr_data[LVL_W-1:0]), .lvl_d(lvl_d), .lvl_q(lvl_q)
   );

   // mask the next state so requests move on the same edge as the state
   sip_req_mask #(.SRC_N(SRC_N), .LVL_W(LVL_W), .FIXED_MSK(FIXED_MSK),
                  .FIXED_THR(FIXED_THR)) u_mask (
      .pend(pend_d), .lvl(lvl_d), .req(req_d)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         req_q <= '0;
      end else begin
         req_q <= req_d;
      end
   end

   assign rd_data = {{PAD_W{1'b0}}, pend_q};
   assign irq_req = req_q;
endmodule

// File: rtl/sip_ctrl_chk.sv
module sip_ctrl_chk #(
   parameter int               SRC_N     = 17,
   parameter int               LVL_W     = 4,
   parameter int               BUS_W     = 32,
   parameter int               TIMER_BIT = 16,
   parameter logic [SRC_N-1:0] FIXED_MSK = 17'h10001,
   parameter int               FIXED_THR = 14
) (
   input logic             clk,
   input logic             rst_n,
   input logic             wr_en,
   input logic [1:0]       wr_sel,
   input logic [BUS_W-1:0] wr_data,
   input logic             tmr_hit,
   input logic [BUS_W-1:0] rd_data,
   input logic [SRC_N-1:0] irq_req,
   input logic [LVL_W-1:0] lvl
);
   p_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_sel == 2'd0 && !tmr_hit) |=>
         rd_data[SRC_N-1:0] == $past(wr_data[SRC_N-1:0]));

   p_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_sel == 2'd1 && !tmr_hit) |=>
         rd_data[SRC_N-1:0] == ($past(rd_data[SRC_N-1:0]) | $past(wr_data[SRC_N-1:0])));

   p_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_sel == 2'd2 && !tmr_hit) |=>
         rd_data[SRC_N-1:0] == ($past(rd_data[SRC_N-1:0]) & ~$past(wr_data[SRC_N-1:0])));

   p_level_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_sel == 2'd3) |=> lvl == $past(wr_data[LVL_W-1:0]));

   p_level_keeps_pend_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_sel == 2'd3 && !tmr_hit) |=> $stable(rd_data));

   p_fixed_gate_r7: assert property (@(posedge clk) disable iff (!rst_n)
      ((irq_req & FIXED_MSK) != '0) |-> (int'(lvl) < FIXED_THR));

   for (genvar g = 0; g < SRC_N; g++) begin : g_rank
      if (!FIXED_MSK[g]) begin : g_chk
         p_rank_gate_r6: assert property (@(posedge clk) disable iff (!rst_n)
            irq_req[g] |-> (rd_data[g] && int'(lvl) < g));
      end
   end

   p_timer_r8: assert property (@(posedge clk) disable iff (!rst_n)
      tmr_hit |=> rd_data[TIMER_BIT]);

   p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (!wr_en && !tmr_hit) |=> ($stable(rd_data) && $stable(irq_req)));

   p_req_only_pending_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_req & ~rd_data[SRC_N-1:0]) == '0);

   p_upper_zero_r11: assert property (@(posedge clk) disable iff (!rst_n)
      rd_data[BUS_W-1:SRC_N] == '0);
endmodule

bind sip_ctrl sip_ctrl_chk #(
   .SRC_N(SRC_N), .LVL_W(LVL_W), .BUS_W(BUS_W), .TIMER_BIT(TIMER_BIT),
   .FIXED_MSK(FIXED_MSK), .FIXED_THR(FIXED_THR)
) u_chk (
   .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
   .wr_data(wr_data), .tmr_hit(tmr_hit), .rd_data(rd_data),
   .irq_req(irq_req), .lvl(lvl_q)
);

// File: tb/sim_sip_ctrl.sv
module sim_sip_ctrl;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [1:0]  wr_sel = 2'd0;
   logic [31:0] wr_data = '0;
   logic        tmr_hit = 1'b0;
   logic [31:0] rd_data;
   logic [16:0] irq_req;

   int checks = 0;
   int errors = 0;
   int cycles = 0;
   logic [16:0] m_pend = '0;
   logic [3:0]  m_lvl = '0;

   always #2.5 clk = ~clk;

   sip_ctrl u0 (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
      .wr_data(wr_data), .tmr_hit(tmr_hit), .rd_data(rd_data),
      .irq_req(irq_req)
   );

   // stimulus rows: {sel[1:0], tmr_hit, data[31:0]}
   localparam int NV = 18;
   localparam logic [34:0] VEC [NV] = '{
      {2'd0, 1'b0, 32'h0001_FFFF},  // R2 load all, level 0
      {2'd3, 1'b0, 32'h0000_0007},  // R5 level 7, R6 cutoff
      {2'd2, 1'b0, 32'h0000_00F0},  // R4 clear 4..7
      {2'd3, 1'b0, 32'h0000_000D},  // R7 level 13, timer bits live
      {2'd3, 1'b0, 32'h0000_000E},  // R7 level 14, timer bits gated
      {2'd3, 1'b0, 32'h0000_000F},  // R6 level 15, all gated
      {2'd0, 1'b0, 32'hFFFE_0000},  // R11 upper bits ignored
      {2'd3, 1'b0, 32'hFFFF_FFF0},  // R5 level 0 with junk upper
      {2'd1, 1'b0, 32'h0000_0001},  // R3 set bit 0
      {2'd1, 1'b0, 32'h0000_8002},  // R3 set 1 and 15
      {2'd0, 1'b1, 32'h0000_0000},  // R9 load zero with timer
      {2'd2, 1'b1, 32'h0001_0000},  // R9 clear bit16 with timer
      {2'd2, 1'b0, 32'h0001_FFFF},  // R4 clear all
      {2'd1, 1'b0, 32'h0000_5555},  // R3 set pattern
      {2'd3, 1'b0, 32'h0000_0008},  // R6 level 8
      {2'd1, 1'b1, 32'h0000_0200},  // R8/R9 set with timer
      {2'd3, 1'b1, 32'h0000_000E},  // R5/R8 level write with timer
      {2'd0, 1'b0, 32'h0000_AAAA}   // R2 load pattern
   };

   function automatic logic [16:0] exp_req(input logic [16:0] p, input logic [3:0] l);
      logic [16:0] r;
      for (int i = 0; i < 17; i++) begin
         if (i == 0 || i == 16) r[i] = p[i] && (l < 4'd14);  // R7
         else                   r[i] = p[i] && (i > int'(l)); // R6
      end
      return r;
   endfunction

   task automatic model(input logic [1:0] s, input logic [31:0] d, input logic t, input logic en);
      if (en) begin
         case (s)
            2'd0: m_pend = d[16:0];
            2'd1: m_pend = m_pend | d[16:0];
            2'd2: m_pend = m_pend & ~d[16:0];
            default: m_lvl = d[3:0];
         endcase
      end
      if (t) m_pend[16] = 1'b1;
   endtask

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic compare(input string tag);
      check({tag, " rd_data"}, rd_data, {15'd0, m_pend});
      check({tag, " irq_req R6/R7/R10"}, {15'd0, irq_req}, {15'd0, exp_req(m_pend, m_lvl)});
   endtask

   // drives at a falling edge, accepted at the next rising edge, checked after it
   task automatic step(input logic en, input logic [1:0] s, input logic [31:0] d, input logic t);
      @(negedge clk);
      wr_en = en; wr_sel = s; wr_data = d; tmr_hit = t;
      @(negedge clk);
      wr_en = 1'b0; tmr_hit = 1'b0; wr_data = '0; wr_sel = 2'd0;
      model(s, d, t, en);
   endtask

   function automatic string sel_tag(input logic [1:0] s);
      case (s)
         2'd0: return "R2 load";
         2'd1: return "R3 set";
         2'd2: return "R4 clear";
         default: return "R5 level";
      endcase
   endfunction

   task automatic finish_up();
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   endtask

   initial begin
      forever begin
         @(posedge clk);
         cycles++;
         if (cycles > 20000) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            finish_up();
         end
      end
   end

   initial begin
      // R1 reset state
      repeat (3) @(negedge clk);
      check("R1 rd_data after reset", rd_data, 32'd0);
      check("R1 irq_req after reset", {15'd0, irq_req}, 32'd0);
      rst_n = 1'b1;
      @(negedge clk);

      for (int v = 0; v < NV; v++) begin
         step(1'b1, VEC[v][34:33], VEC[v][31:0], VEC[v][32]);
         compare(sel_tag(VEC[v][34:33]));
      end

      // R9 direct load clearing bit 16 during a timer pulse keeps bit 16
      step(1'b1, 2'd0, 32'h0000_0003, 1'b1);
      check("R9 bit16 survives load", {31'd0, rd_data[16]}, 32'd1);
      compare("R9 load+timer");

      // R8 timer pulse alone, level 13 then 14 boundary
      step(1'b1, 2'd0, 32'h0, 1'b0);
      step(1'b1, 2'd3, 32'h0000_000D, 1'b0);
      step(1'b0, 2'd0, 32'h0, 1'b1);
      check("R8 timer pulse sets bit 16", rd_data, 32'h0001_0000);
      check("R7 level 13 timer request", {15'd0, irq_req}, 32'h0001_0000);
      step(1'b1, 2'd3, 32'h0000_000E, 1'b0);
      check("R7 level 14 timer gated", {15'd0, irq_req}, 32'd0);

      // R10 idle cycles hold state
      step(1'b1, 2'd3, 32'h0000_0002, 1'b0);
      step(1'b1, 2'd0, 32'h0000_000C, 1'b0);
      repeat (4) @(negedge clk);
      check("R10 hold rd_data", rd_data, 32'h0000_000C);
      check("R10 hold irq_req", {15'd0, irq_req}, 32'h0000_0008);

      // R6 sweep level across every middle source
      step(1'b1, 2'd0, 32'h0000_FFFE, 1'b0);
      for (int l = 0; l < 16; l++) begin
         step(1'b1, 2'd3, 32'(l), 1'b0);
         compare("R6 sweep");
      end

      // R1 reset mid-run clears everything
      step(1'b1, 2'd0, 32'h0001_0001, 1'b0);
      @(negedge clk);
      rst_n = 1'b0;
      @(negedge clk);
      check("R1 rd_data after mid reset", rd_data, 32'd0);
      check("R1 irq_req after mid reset", {15'd0, irq_req}, 32'd0);
      rst_n = 1'b1;
      m_pend = '0; m_lvl = '0;
      // level back at 0 lets bit 16 request (R1 level clear observed)
      step(1'b1, 2'd1, 32'h0001_0000, 1'b0);
      check("R1 level zero after reset", {15'd0, irq_req}, 32'h0001_0000);

      finish_up();
   end
endmodule